// File: doc/BRIEF.md
# Field Sensor Measurement Sequencer

This block sequences power modes and measurements for a three-axis magnetic field sensor that a host controls through a small register interface. A two-bit mode register selects continuous measurement, single measurement, idle or sleep. A configuration register holds a rate code and the self-test bias polarity. A gain register holds a three-bit range code that is passed straight to the front end. Each measurement converts the X, Y and Z axes in that order through a start/done handshake with the converter. All three results are then committed together into the readable axis registers, and a data-ready flag is raised.

The host always wins over the sequencer. No conversion is started in a cycle in which the host bus is active, and a conversion that is due is held back until the access has finished. After a single measurement the sequencer writes its own mode field to sleep. In continuous mode it powers the analog path down between samples and leaves the mode field unchanged. Once the host has begun reading a sample, the axis registers are held until the last axis byte has been read. Any sample that completes in the meantime is transferred at that point.

Top module: `field_seq`

## Requirements
- R1: After reset the mode register reads 01 (single), the configuration register reads 0x10 (rate code 4, bias none), the gain register reads 0x20 (code 1) and `drdy` is low. While `bus_req` stays high from reset, no conversion starts.
- R2: In single mode the axes are converted in the order X (axis 0), Y (axis 1), Z (axis 2). After the third conversion completes, the mode field reads 11 (sleep) and `analog_en` is low.
- R3: In continuous mode (mode 00), conversion of axis 0 starts every 2^(4+rate) clock cycles when the three conversions fit in that time and the bus is quiet. The mode field stays 00, and `analog_en` is low between samples.
- R4: In idle mode (mode 10), `analog_en`, `bias_pos` and `bias_neg` are low, `clk_run` is high, and the configuration and gain registers keep their values.
- R5: In sleep mode, `clk_run` is low and `analog_en` is low. Writing mode 01 or 00 from sleep or idle raises `analog_en` in the cycle after the write.
- R6: Configuration bits [1:0] select the bias: 01 drives `bias_pos`, 10 drives `bias_neg`, and 00 or 11 drive neither. Bias is applied only while `analog_en` is high, and the two bias outputs are never high together.
- R7: Bits [7:5] written to address 1 appear on `gain_sel` from the cycle after the write.
- R8: `adc_start` is never high in a cycle in which `bus_req` is high.
- R9: Address 9 bit 0, like `drdy`, is set when a sample is committed. It is cleared by a read of address 8 unless a held-back sample is waiting.
- R10: A read of any address from 3 to 7 freezes the axis registers. Until address 8 is read, a newly completed sample is not shown. The read of address 8 then shows that sample and keeps `drdy` high.
- R11: Writes to the axis registers (addresses 3 to 8) have no effect on their read values.
- R12: Addresses 3/4, 5/6 and 7/8 hold the high and low bytes of the X, Y and Z samples, sign-extended to 16 bits. Read data appears on `bus_rdata` one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access strobe, one access per high cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the request |
| adc_start | output | 1 | Start a conversion of `adc_axis` |
| adc_axis | output | 2 | Axis being converted (0 X, 1 Y, 2 Z) |
| adc_done | input | 1 | Conversion complete, `adc_data` valid |
| adc_data | input | DW | Signed conversion result |
| analog_en | output | 1 | Enables the amplifier, converter, sensor supply and bias |
| bias_pos | output | 1 | Positive self-test bias on the offset strap |
| bias_neg | output | 1 | Negative self-test bias on the offset strap |
| gain_sel | output | 3 | Range code for the front end |
| clk_run | output | 1 | Internal clock enable, low in sleep |
| drdy | output | 1 | New sample committed and not yet fully read |

## Verification
Single measurements are run from sleep with each of the four bias codes. This separates a correct bias encoding and axis order from a swapped or stuck one. Continuous runs at two rate codes measure the start-to-start distance, which shows whether the prescale shift is correct. A long stretch of held bus traffic during continuous mode must stop all starts, which exposes a sequencer that ignores priority. The frozen-read pattern, in which a new sample arrives between the first and last axis byte, tells a proper snapshot apart from a torn one. Random writes and reads of configuration, gain and axis addresses cover field masking and the read-only data.

// File: rtl/field_seq.sv
module field_seq #(
  parameter int DW = 16,
  parameter int BASE_LOG = 4,
  parameter logic [2:0] RATE_RST = 3'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [3:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          adc_start,
  output logic [1:0]    adc_axis,
  input  logic          adc_done,
  input  logic [DW-1:0] adc_data,
  output logic          analog_en,
  output logic          bias_pos,
  output logic          bias_neg,
  output logic [2:0]    gain_sel,
  output logic          clk_run,
  output logic          drdy
);
  localparam int NAX = 3;
  localparam int TW = BASE_LOG + 8;
  localparam logic [1:0] M_CONT = 2'd0, M_SINGLE = 2'd1, M_IDLE = 2'd2, M_SLEEP = 2'd3;
  localparam logic [3:0] A_CFG = 4'd0, A_GAIN = 4'd1, A_MODE = 4'd2, A_X_HI = 4'd3,
                         A_Z_LO = 4'd8, A_STAT = 4'd9;

  typedef enum logic [1:0] {ST_OFF, ST_CONV, ST_WAIT} st_t;

  st_t              st_q;
  logic [1:0]       mode_q, bias_q, axis_q;
  logic [2:0]       rate_q, gain_q;
  logic             wait_q, lock_q, pend_q, drdy_q;
  logic [TW-1:0]    tmr_q, period;
  logic [DW-1:0]    shad_q [NAX];
  logic [DW-1:0]    out_q  [NAX];
  logic [DW-1:0]    nxt_q  [NAX];
  logic [DW-1:0]    fresh  [NAX];
  logic [15:0]      wide   [NAX];

  logic wr, rd, wr_mode, rd_last, rd_hold, last_done, go_mode;

  assign wr        = bus_req & bus_we;
  assign rd        = bus_req & ~bus_we;
  assign wr_mode   = wr && bus_addr == A_MODE;
  assign go_mode   = bus_wdata[1:0] == M_CONT || bus_wdata[1:0] == M_SINGLE;
  assign rd_last   = rd && bus_addr == A_Z_LO;
  assign rd_hold   = rd && bus_addr >= A_X_HI && bus_addr < A_Z_LO;
  assign last_done = st_q == ST_CONV && wait_q && adc_done && axis_q == 2'd2;
  assign period    = TW'(1) << (BASE_LOG + int'(rate_q));

  assign adc_start = st_q == ST_CONV && !wait_q && !bus_req;
  assign adc_axis  = axis_q;
  assign analog_en = st_q == ST_CONV;
  assign bias_pos  = analog_en && bias_q == 2'b01;
  assign bias_neg  = analog_en && bias_q == 2'b10;
  assign gain_sel  = gain_q;
  assign clk_run   = mode_q != M_SLEEP;
  assign drdy      = drdy_q;

  generate
    for (genvar g = 0; g < NAX; g++) begin : g_ax
      assign wide[g]  = 16'($signed(out_q[g]));
      assign fresh[g] = (g == NAX - 1) ? adc_data : shad_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_RST;
      bias_q <= 2'b00;
      gain_q <= 3'd1;
    end else if (wr && bus_addr == A_CFG) begin
      rate_q <= bus_wdata[4:2];
      bias_q <= bus_wdata[1:0];
    end else if (wr && bus_addr == A_GAIN) begin
      gain_q <= bus_wdata[7:5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               mode_q <= M_SINGLE;
    else if (wr_mode)                         mode_q <= bus_wdata[1:0];
    else if (last_done && mode_q == M_SINGLE) mode_q <= M_SLEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      axis_q <= 2'd0;
      wait_q <= 1'b0;
      tmr_q  <= '0;
      for (int i = 0; i < NAX; i++) shad_q[i] <= '0;
    end else begin
      if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
      if (wr_mode) begin
        wait_q <= 1'b0;
        axis_q <= 2'd0;
        if (go_mode) begin
          st_q  <= ST_CONV;
          tmr_q <= period - 1'b1;
        end else begin
          st_q <= ST_OFF;
        end
      end else begin
        case (st_q)
          ST_OFF:
            if ((mode_q == M_CONT || mode_q == M_SINGLE) && !bus_req) begin
              st_q  <= ST_CONV;
              tmr_q <= period - 1'b1;
            end
          ST_CONV:
            if (!wait_q) begin
              if (!bus_req) wait_q <= 1'b1;
            end else if (adc_done) begin
              wait_q         <= 1'b0;
              shad_q[axis_q] <= adc_data;
              if (axis_q == 2'd2) begin
                axis_q <= 2'd0;
                st_q   <= (mode_q == M_CONT) ? ST_WAIT : ST_OFF;
              end else begin
                axis_q <= axis_q + 1'b1;
              end
            end
          ST_WAIT:
            if (tmr_q == '0 && !bus_req) begin
              st_q  <= ST_CONV;
              tmr_q <= period - 1'b1;
            end
          default: st_q <= ST_OFF;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      pend_q <= 1'b0;
      drdy_q <= 1'b0;
      for (int i = 0; i < NAX; i++) begin
        out_q[i] <= '0;
        nxt_q[i] <= '0;
      end
    end else begin
      if (rd_hold)      lock_q <= 1'b1;
      else if (rd_last) lock_q <= 1'b0;
      if (last_done) begin
        if (lock_q && !rd_last) begin
          pend_q <= 1'b1;
          for (int i = 0; i < NAX; i++) nxt_q[i] <= fresh[i];
        end else begin
          pend_q <= 1'b0;
          drdy_q <= 1'b1;
          for (int i = 0; i < NAX; i++) out_q[i] <= fresh[i];
        end
      end else if (rd_last) begin
        if (pend_q) begin
          pend_q <= 1'b0;
          drdy_q <= 1'b1;
          for (int i = 0; i < NAX; i++) out_q[i] <= nxt_q[i];
        end else begin
          drdy_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= 8'h00;
    else if (rd) begin
      case (bus_addr)
        A_CFG:   bus_rdata <= {3'b000, rate_q, bias_q};
        A_GAIN:  bus_rdata <= {gain_q, 5'b00000};
        A_MODE:  bus_rdata <= {6'b000000, mode_q};
        4'd3:    bus_rdata <= wide[0][15:8];
        4'd4:    bus_rdata <= wide[0][7:0];
        4'd5:    bus_rdata <= wide[1][15:8];
        4'd6:    bus_rdata <= wide[1][7:0];
        4'd7:    bus_rdata <= wide[2][15:8];
        4'd8:    bus_rdata <= wide[2][7:0];
        A_STAT:  bus_rdata <= {7'b0000000, drdy_q};
        default: bus_rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/field_seq_chk.sv
module field_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_we,
  input logic [3:0] bus_addr,
  input logic       adc_start,
  input logic       adc_done,
  input logic       analog_en,
  input logic       bias_pos,
  input logic       bias_neg,
  input logic       drdy,
  input logic [1:0] mode_q,
  input logic [1:0] axis_q,
  input logic       wait_q,
  input logic       pend_q
);
  logic wr_mode, fin;
  assign wr_mode = bus_req && bus_we && bus_addr == 4'd2;
  assign fin     = analog_en && wait_q && adc_done && axis_q == 2'd2;

  a_r8_bus_first: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !adc_start);
  a_r6_bias_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bias_pos && bias_neg));
  a_r6_bias_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_pos || bias_neg) |-> analog_en);
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2) |-> !analog_en);
  a_r5_sleep_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3) |-> !analog_en);
  a_r2_single_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && mode_q == 2'd1 && !wr_mode) |=> (mode_q == 2'd3 && !analog_en));
  a_r3_cont_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && !wr_mode) |=> mode_q == 2'd0);
  a_r9_drdy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr == 4'd8 && !pend_q && !fin) |=> !drdy);
endmodule

bind field_seq field_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .adc_start(adc_start), .adc_done(adc_done), .analog_en(analog_en),
  .bias_pos(bias_pos), .bias_neg(bias_neg), .drdy(drdy),
  .mode_q(mode_q), .axis_q(axis_q), .wait_q(wait_q), .pend_q(pend_q)
);

// File: tb/field_seq_tb.sv
module field_seq_tb;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic adc_start, adc_done;
  logic [1:0] adc_axis;
  logic [15:0] adc_data;
  logic analog_en, bias_pos, bias_neg, clk_run, drdy;
  logic [2:0] gain_sel;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  field_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_start(adc_start), .adc_axis(adc_axis),
    .adc_done(adc_done), .adc_data(adc_data), .analog_en(analog_en), .bias_pos(bias_pos),
    .bias_neg(bias_neg), .gain_sel(gain_sel), .clk_run(clk_run), .drdy(drdy)
  );

  // behavioural converter and observation
  int cyc = 0, nsamp = 0, ntrip = 0, nstart0 = 0, order_err = 0, start_in_req = 0;
  int prev_start = -1, last_interval = 0;
  int m_cnt = 0, m_ax = 0, m_b = 0, exp_ax = 0;
  bit m_busy = 0;
  logic [15:0] lastv [3];
  logic [15:0] tripv [3];
  int lastb [3];

  function automatic logic [15:0] conv_val(int ax, int n, int b);
    int v;
    v = 100 * ax + 7 * n + (b == 1 ? 500 : (b == 2 ? -500 : 0));
    return 16'(v);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    adc_done <= 1'b0;
    if (!rst_n) begin
      m_busy = 0;
    end else if (adc_start) begin
      if (bus_req) start_in_req++;
      if (adc_axis != 2'(exp_ax)) order_err++;
      exp_ax = (exp_ax + 1) % 3;
      if (adc_axis == 2'd0) begin
        nstart0++;
        if (prev_start >= 0) last_interval = cyc - prev_start;
        prev_start = cyc;
      end
      m_busy = 1;
      m_cnt = LAT;
      m_ax = int'(adc_axis);
      m_b = bias_pos ? 1 : (bias_neg ? 2 : 0);
      lastb[m_ax] = m_b;
    end else if (m_busy) begin
      if (m_cnt == 1) begin
        adc_done <= 1'b1;
        adc_data <= conv_val(m_ax, nsamp, m_b);
        lastv[m_ax] = conv_val(m_ax, nsamp, m_b);
        nsamp++;
        m_busy = 0;
        if (m_ax == 2) begin
          for (int i = 0; i < 3; i++) tripv[i] = lastv[i];
          ntrip++;
        end
      end else begin
        m_cnt--;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_sample(string req, logic [15:0] ev [3]);
    logic [7:0] hi, lo;
    for (int i = 0; i < 3; i++) begin
      rd(4'(3 + 2 * i), hi);
      rd(4'(4 + 2 * i), lo);
      check({hi, lo} == ev[i], req, {hi, lo}, ev[i]);
    end
  endtask

  initial begin : main
    logic [7:0] d;
    logic [15:0] snap [3];
    logic [7:0] cfg_m, gain_m;
    int s0;
    void'($urandom(20240611));
    for (int i = 0; i < 3; i++) begin lastv[i] = '0; tripv[i] = '0; lastb[i] = 0; end
    adc_data = '0;
    // R1: reset defaults, with the bus busy so nothing starts
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 4'd2;
    idle_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_rdata == 8'h01, "R1 mode default", bus_rdata, 8'h01);
    bus_addr = 4'd0;
    @(negedge clk);
    check(bus_rdata == 8'h10, "R1 config default", bus_rdata, 8'h10);
    bus_addr = 4'd1;
    @(negedge clk);
    check(bus_rdata == 8'h20, "R1 gain default", bus_rdata, 8'h20);
    check(drdy == 1'b0 && nstart0 == 0, "R1 drdy low and no start", {drdy, 8'(nstart0)}, 0);
    bus_req = 1'b0;
    // R2: default single measurement
    idle_cycles(40);
    rd(4'd2, d);
    check(d == 8'h03, "R2 mode sleeps after single", d, 3);
    check(ntrip == 1 && order_err == 0, "R2 one sample in axis order", ntrip * 16 + order_err, 16);
    check(!analog_en, "R2 analog off", analog_en, 0);
    check(!clk_run, "R5 clock stopped in sleep", clk_run, 0);
    rd(4'd9, d);
    check(d == 8'h01 && drdy, "R9 status set", d, 1);
    check_sample("R12 sample bytes", tripv);
    check(!drdy, "R9 drdy cleared by last byte", drdy, 0);
    // R5: wake from sleep
    wr(4'd2, 8'h01);
    check(analog_en, "R5 analog up cycle after write", analog_en, 1);
    idle_cycles(40);
    check(ntrip == 2, "R5 sample taken after wake", ntrip, 2);
    // R6: bias encodings
    for (int b = 0; b < 4; b++) begin
      wr(4'd0, 8'(8'h10 | b));
      wr(4'd2, 8'h01);
      idle_cycles(40);
      for (int i = 0; i < 3; i++)
        check(lastb[i] == ((b == 1 || b == 2) ? b : 0), "R6 bias seen by converter", lastb[i], b);
      check_sample("R6 biased sample", tripv);
    end
    // R7: gain
    wr(4'd1, 8'hA0);
    check(gain_sel == 3'd5, "R7 gain output", gain_sel, 5);
    // R4: idle
    wr(4'd2, 8'h02);
    check(!analog_en && clk_run && !bias_pos && !bias_neg, "R4 idle outputs",
          {analog_en, clk_run, bias_pos, bias_neg}, 4'b0100);
    rd(4'd0, d);
    check(d == 8'h13, "R4 config retained", d, 8'h13);
    rd(4'd1, d);
    check(d == 8'hA0, "R4 gain retained", d, 8'hA0);
    // R11: data registers read-only
    wr(4'd3, 8'h55);
    wr(4'd8, 8'hAA);
    check_sample("R11 write to data ignored", tripv);
    // R10: freeze while partially read
    wr(4'd0, 8'h10);
    wr(4'd2, 8'h01);
    idle_cycles(40);
    for (int i = 0; i < 3; i++) snap[i] = tripv[i];
    rd(4'd3, d);
    check(d == snap[0][15:8], "R10 first byte", d, snap[0][15:8]);
    s0 = ntrip;
    wr(4'd2, 8'h01);
    idle_cycles(40);
    check(ntrip == s0 + 1, "R10 new sample taken", ntrip, s0 + 1);
    rd(4'd4, d); check(d == snap[0][7:0], "R10 frozen X lo", d, snap[0][7:0]);
    rd(4'd5, d); check(d == snap[1][15:8], "R10 frozen Y hi", d, snap[1][15:8]);
    rd(4'd6, d); check(d == snap[1][7:0], "R10 frozen Y lo", d, snap[1][7:0]);
    rd(4'd7, d); check(d == snap[2][15:8], "R10 frozen Z hi", d, snap[2][15:8]);
    rd(4'd8, d); check(d == snap[2][7:0], "R10 frozen Z lo", d, snap[2][7:0]);
    check(drdy, "R10 pending sample raises drdy", drdy, 1);
    check_sample("R10 pending sample shown", tripv);
    check(!drdy, "R9 drdy clear after pending read", drdy, 0);
    // R3: continuous rate
    wr(4'd0, 8'h04);
    wr(4'd2, 8'h00);
    idle_cycles(200);
    check(last_interval == 32, "R3 period rate 1", last_interval, 32);
    rd(4'd2, d);
    check(d == 8'h00, "R3 mode kept", d, 0);
    wr(4'd0, 8'h08);
    idle_cycles(300);
    check(last_interval == 64, "R3 period rate 2", last_interval, 64);
    s0 = nstart0;
    while (nstart0 == s0) @(negedge clk);
    idle_cycles(40);
    check(!analog_en, "R3 analog off between samples", analog_en, 0);
    // R8: bus priority
    wr(4'd0, 8'h00);
    idle_cycles(40);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 4'd9;
    @(negedge clk);
    s0 = nsamp + (m_busy ? 1 : 0);
    idle_cycles(100);
    bus_req = 1'b0;
    check(start_in_req == 0, "R8 no start during access", start_in_req, 0);
    check(nsamp == s0, "R8 sampling paused", nsamp, s0);
    idle_cycles(40);
    check(nsamp > s0, "R8 sampling resumes", nsamp, s0 + 1);
    // random register traffic (idle mode)
    wr(4'd2, 8'h02);
    idle_cycles(30);
    for (int i = 0; i < 3; i++) snap[i] = tripv[i];
    rd(4'd0, cfg_m);
    rd(4'd1, gain_m);
    for (int k = 0; k < 40; k++) begin
      int a;
      logic [7:0] v;
      a = int'($urandom_range(0, 8));
      v = 8'($urandom);
      if (a == 2) a = 1;
      wr(4'(a), v);
      if (a == 0) cfg_m = v & 8'h1F;
      if (a == 1) gain_m = v & 8'hE0;
      rd(4'd0, d);
      check(d == cfg_m, "R4 random config", d, cfg_m);
      rd(4'd1, d);
      check(d == gain_m && gain_sel == gain_m[7:5], "R7 random gain", d, gain_m);
      if (a >= 3) begin
        rd(4'(a), d);
        check(d == (a[0] ? snap[(a - 3) / 2][15:8] : snap[(a - 3) / 2][7:0]),
              "R11 random data write ignored", d, 0);
      end
    end
    check(order_err == 0, "R2 axis order overall", order_err, 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule